// File: doc/BRIEF.md
# Predicated Element Step Skipper

This block sits in the element loop of a vector issue stage. At the start of every element step it is handed the current source and destination element indices, the active vector length, a predicate mode, the two candidate mask pairs and the two zeroing controls. It then decides where each index really lands. A side without zeroing is moved forward past elements that its mask disables. A side with zeroing keeps its index and instead raises a zero flag when that element is disabled.

The vector length doubles as a sentinel. If either index lands on it, or the vector length is zero, the block raises an end indication so that the sequencer skips the operation and resets its loop. The scan walks one element per clock behind a start/done handshake. Results stay on the outputs, unchanged, until the next accepted start.

Top module: `elem_step_skipper`

## Requirements
- R1: After a synchronous reset, busy_o and done_o are 0 and both result indices, both zero flags and end_o are 0.
- R2: With pred_mode_i equal to 2'b00 or the unused code 2'b11, both masks are all ones over the 64 element positions.
- R3: With pred_mode_i equal to 2'b01, the destination mask is int_dst_mask_i. The source mask is int_src_mask_i when twin_i is 1, and int_dst_mask_i otherwise.
- R4: With pred_mode_i equal to 2'b10, the same selection rule applies to cr_src_mask_i and cr_dst_mask_i. Mask bits at positions at or above the vector length are treated as 0.
- R5: A side with zeroing off returns the lowest index that is at or above its start index and below the vector length whose mask bit is 1. If there is none, it returns the vector length. A start index already at or above the vector length is returned unchanged. Positions 64 and above count as mask bit 0.
- R6: A side with zeroing on returns its start index unchanged. Its zero flag is 1 exactly when the mask bit at that index is 0. The flag of a side with zeroing off is 0.
- R7: end_o is 1 when either returned index equals the vector length.
- R8: A vector length of 0 always gives end_o = 1.
- R9: done_o rises exactly N+1 clock edges after the edge that accepts start_i, where N is the larger of the two sides' advance distances. busy_o is high in between, and busy_o and done_o are never both high.
- R10: A start_i while busy_o is high is ignored. After done_o the outputs hold their values until the next accepted start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a scan; accepted when not busy |
| src_step_i | input | 7 | Starting source element index |
| dst_step_i | input | 7 | Starting destination element index |
| vl_i | input | 7 | Vector length (sentinel index) |
| pred_mode_i | input | 2 | 00 none, 01 integer masks, 10 condition masks, 11 none |
| twin_i | input | 1 | Separate source predicate in use |
| src_zero_en_i | input | 1 | Zeroing on the source side |
| dst_zero_en_i | input | 1 | Zeroing on the destination side |
| int_src_mask_i | input | 64 | Integer-mode source predicate |
| int_dst_mask_i | input | 64 | Integer-mode destination predicate |
| cr_src_mask_i | input | 64 | Condition-mode source predicate |
| cr_dst_mask_i | input | 64 | Condition-mode destination predicate |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Results valid, held until next start |
| src_step_o | output | 7 | Resulting source index |
| dst_step_o | output | 7 | Resulting destination index |
| src_zero_o | output | 1 | Source element must be treated as zero |
| dst_zero_o | output | 1 | Destination element must be zeroed |
| end_o | output | 1 | Loop finished; operation is skipped |

## Verification
The bench sweeps vector lengths from 0 to 11 against thinned random masks, start indices on both sides of the vector length, all four mode codes, twin on and off, and every zeroing pair. A model computes the next set bit, saturating at the vector length. Directed cases cover the following. A start index above 63 must walk to the sentinel rather than wrap or read a stray bit. A condition-mode mask must report a zero flag past the vector length where integer mode does not; a design that skipped the truncation would clear it. A source mask taken from the destination selection would show up only with twin set. A start pulse in the middle of a scan must not restart the scan; a design that accepted it would return the second request's indices. Latency is counted on every run, so a scanner that takes an extra cycle or finishes one side early is caught.

// File: rtl/elem_skip_pkg.sv
package elem_skip_pkg;

    parameter int MASK_W = 64;
    parameter int STEP_W = 7;
    localparam int SIDES = 2;
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [MASK_W-1:0] mask_t;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_INT  = 2'b01,
        PM_CR   = 2'b10,
        PM_RSVD = 2'b11
    } pmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } skip_state_e;

    typedef struct packed {
        step_t step;
        logic  zero;
    } side_res_t;

    // Mask bit at an element position; positions past the mask width read as 0.
    function automatic logic mask_bit(input mask_t m, input step_t idx);
        mask_t shifted;
        shifted = m >> idx;
        return (int'(idx) < MASK_W) ? shifted[0] : 1'b0;
    endfunction

    // Ones in every position below the vector length.
    function automatic mask_t below_vl(input step_t vl);
        if (int'(vl) >= MASK_W)
            return '1;
        return (mask_t'(1) << vl) - mask_t'(1);
    endfunction

endpackage

// File: rtl/pred_mask_select.sv
module pred_mask_select
    import elem_skip_pkg::*;
(
    input  pmode_e mode,
    input  logic   twin,
    input  step_t  vl,
    input  mask_t  int_src,
    input  mask_t  int_dst,
    input  mask_t  cr_src,
    input  mask_t  cr_dst,
    output mask_t  src_mask,
    output mask_t  dst_mask
);

    mask_t cr_window;

    always_comb begin
        cr_window = below_vl(vl);
        unique case (mode)
            PM_INT: begin
                dst_mask = int_dst;
                src_mask = twin ? int_src : int_dst;
            end
            PM_CR: begin
                dst_mask = cr_dst & cr_window;
                src_mask = (twin ? cr_src : cr_dst) & cr_window;
            end
            default: begin
                dst_mask = '1;
                src_mask = '1;
            end
        endcase
    end

endmodule

// File: rtl/step_scanner.sv
module step_scanner
    import elem_skip_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  step_t     step_in,
    input  mask_t     mask_in,
    input  logic      zero_en_in,
    input  step_t     vl_in,
    output side_res_t res,
    output logic      fin
);

    step_t idx_q;
    step_t vl_q;
    mask_t mask_q;
    logic  zen_q;
    logic  cur_bit;

    always_comb begin
        cur_bit  = mask_bit(mask_q, idx_q);
        fin      = zen_q || (idx_q >= vl_q) || cur_bit;
        res.step = idx_q;
        res.zero = zen_q && !cur_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            vl_q   <= '0;
            mask_q <= '0;
            zen_q  <= 1'b0;
        end else if (load) begin
            idx_q  <= step_in;
            vl_q   <= vl_in;
            mask_q <= mask_in;
            zen_q  <= zero_en_in;
        end else if (!fin) begin
            idx_q  <= idx_q + step_t'(1);
        end
    end

    // R5
    idx_no_retreat_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> idx_q >= $past(idx_q));

    // R6
    zero_side_still_chk: assert property (@(posedge clk) disable iff (rst)
        (zen_q && !load) |=> $stable(idx_q));

    // R5
    sentinel_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && idx_q < vl_q) |=> idx_q <= vl_q);

endmodule

// File: rtl/elem_step_skipper.sv
module elem_step_skipper
    import elem_skip_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [6:0]  src_step_i,
    input  logic [6:0]  dst_step_i,
    input  logic [6:0]  vl_i,
    input  logic [1:0]  pred_mode_i,
    input  logic        twin_i,
    input  logic        src_zero_en_i,
    input  logic        dst_zero_en_i,
    input  logic [63:0] int_src_mask_i,
    input  logic [63:0] int_dst_mask_i,
    input  logic [63:0] cr_src_mask_i,
    input  logic [63:0] cr_dst_mask_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [6:0]  src_step_o,
    output logic [6:0]  dst_step_o,
    output logic        src_zero_o,
    output logic        dst_zero_o,
    output logic        end_o
);

    skip_state_e state_q;
    logic        accept;
    logic        all_fin;
    step_t       vl_q;
    mask_t       sel_src, sel_dst;
    side_res_t   side_res [SIDES];
    logic        side_fin [SIDES];
    side_res_t   out_src_q, out_dst_q;
    logic        end_q, done_q;

    assign accept  = start_i && (state_q == ST_IDLE);
    assign all_fin = side_fin[SIDE_SRC] && side_fin[SIDE_DST];

    pred_mask_select u_sel (
        .mode     (pmode_e'(pred_mode_i)),
        .twin     (twin_i),
        .vl       (vl_i),
        .int_src  (int_src_mask_i),
        .int_dst  (int_dst_mask_i),
        .cr_src   (cr_src_mask_i),
        .cr_dst   (cr_dst_mask_i),
        .src_mask (sel_src),
        .dst_mask (sel_dst)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        step_scanner u_scan (
            .clk        (clk),
            .rst        (rst),
            .load       (accept),
            .step_in    ((g == SIDE_SRC) ? src_step_i : dst_step_i),
            .mask_in    ((g == SIDE_SRC) ? sel_src : sel_dst),
            .zero_en_in ((g == SIDE_SRC) ? src_zero_en_i : dst_zero_en_i),
            .vl_in      (vl_i),
            .res        (side_res[g]),
            .fin        (side_fin[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            vl_q      <= '0;
            out_src_q <= '0;
            out_dst_q <= '0;
            end_q     <= 1'b0;
            done_q    <= 1'b0;
        end else if (accept) begin
            state_q <= ST_SCAN;
            vl_q    <= vl_i;
            done_q  <= 1'b0;
        end else if (state_q == ST_SCAN && all_fin) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            out_src_q <= side_res[SIDE_SRC];
            out_dst_q <= side_res[SIDE_DST];
            end_q     <= (side_res[SIDE_SRC].step == vl_q) ||
                         (side_res[SIDE_DST].step == vl_q) ||
                         (vl_q == '0);
        end
    end

    assign busy_o     = (state_q == ST_SCAN);
    assign done_o     = done_q;
    assign src_step_o = out_src_q.step;
    assign dst_step_o = out_dst_q.step;
    assign src_zero_o = out_src_q.zero;
    assign dst_zero_o = out_dst_q.zero;
    assign end_o      = end_q;

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy_o, done_o}));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(src_step_o) &&
                                  $stable(dst_step_o) && $stable(end_o) &&
                                  $stable(src_zero_o) && $stable(dst_zero_o)));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || done_o));

    // R8
    zero_length_end_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(done_o) && vl_q == '0) |-> end_o);

    // R7
    sentinel_end_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(done_o) && (src_step_o == vl_q || dst_step_o == vl_q)) |-> end_o);

endmodule

// File: tb/test_elem_step_skipper.sv
`timescale 1ns/1ps
module test_elem_step_skipper;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [6:0]  src_step_i, dst_step_i, vl_i;
    logic [1:0]  pred_mode_i;
    logic        twin_i, src_zero_en_i, dst_zero_en_i;
    logic [63:0] int_src_mask_i, int_dst_mask_i, cr_src_mask_i, cr_dst_mask_i;
    logic        busy_o, done_o, src_zero_o, dst_zero_o, end_o;
    logic [6:0]  src_step_o, dst_step_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    elem_step_skipper i_elem_step_skipper (
        .clk(clk), .rst(rst), .start_i(start_i),
        .src_step_i(src_step_i), .dst_step_i(dst_step_i), .vl_i(vl_i),
        .pred_mode_i(pred_mode_i), .twin_i(twin_i),
        .src_zero_en_i(src_zero_en_i), .dst_zero_en_i(dst_zero_en_i),
        .int_src_mask_i(int_src_mask_i), .int_dst_mask_i(int_dst_mask_i),
        .cr_src_mask_i(cr_src_mask_i), .cr_dst_mask_i(cr_dst_mask_i),
        .busy_o(busy_o), .done_o(done_o),
        .src_step_o(src_step_o), .dst_step_o(dst_step_o),
        .src_zero_o(src_zero_o), .dst_zero_o(dst_zero_o), .end_o(end_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit mbit(input logic [63:0] m, input int idx);
        return (idx < 64) ? m[idx] : 1'b0;
    endfunction

    function automatic int advance(input logic [63:0] m, input int idx, input int vl, input bit zen);
        int i = idx;
        if (zen) return i;
        while (i < vl && !mbit(m, i)) i++;
        return i;
    endfunction

    // Drive one request, then compare against the model.
    task automatic run_case(input string tag);
        logic [63:0] ms, md, win;
        int es, ed, lat, exp_lat;
        bit ezs, ezd, eend;
        win = (vl_i >= 64) ? '1 : ((64'd1 << vl_i) - 64'd1);
        case (pred_mode_i)
            2'b01: begin md = int_dst_mask_i; ms = twin_i ? int_src_mask_i : int_dst_mask_i; end
            2'b10: begin md = cr_dst_mask_i & win; ms = (twin_i ? cr_src_mask_i : cr_dst_mask_i) & win; end
            default: begin md = '1; ms = '1; end
        endcase
        es  = advance(ms, int'(src_step_i), int'(vl_i), src_zero_en_i);
        ed  = advance(md, int'(dst_step_i), int'(vl_i), dst_zero_en_i);
        ezs = src_zero_en_i && !mbit(ms, int'(src_step_i));
        ezd = dst_zero_en_i && !mbit(md, int'(dst_step_i));
        eend = (es == int'(vl_i)) || (ed == int'(vl_i)) || (vl_i == 0);
        exp_lat = ((es - int'(src_step_i)) > (ed - int'(dst_step_i)) ?
                   (es - int'(src_step_i)) : (ed - int'(dst_step_i))) + 1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " R9 latency"}, lat, exp_lat);
        check({tag, " R5 src index"}, src_step_o, es);
        check({tag, " R5 dst index"}, dst_step_o, ed);
        check({tag, " R6 src zero"}, src_zero_o, ezs);
        check({tag, " R6 dst zero"}, dst_zero_o, ezd);
        check({tag, " R7 end"}, end_o, eend);
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0;
        src_step_i = '0; dst_step_i = '0; vl_i = '0; pred_mode_i = '0;
        twin_i = 0; src_zero_en_i = 0; dst_zero_en_i = 0;
        int_src_mask_i = '0; int_dst_mask_i = '0; cr_src_mask_i = '0; cr_dst_mask_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 indices", {src_step_o, dst_step_o}, 0);
        check("R1 flags", {src_zero_o, dst_zero_o, end_o}, 0);

        // R2 R3 R4 R5 R6 R7 R8 sweep
        for (int vl = 0; vl < 12; vl++) begin
            for (int p = 0; p < 40; p++) begin
                vl_i = 7'(vl);
                pred_mode_i = 2'(p % 4);
                twin_i = p[2];
                src_zero_en_i = p[3];
                dst_zero_en_i = p[4];
                src_step_i = 7'($urandom_range(0, 13));
                dst_step_i = 7'($urandom_range(0, 13));
                int_src_mask_i = {$urandom, $urandom} & {$urandom, $urandom};
                int_dst_mask_i = {$urandom, $urandom} & {$urandom, $urandom};
                cr_src_mask_i  = {$urandom, $urandom} & {$urandom, $urandom};
                cr_dst_mask_i  = {$urandom, $urandom} & {$urandom, $urandom};
                run_case("sweep");
            end
        end

        // R2 no-predicate mode keeps indices
        pred_mode_i = 2'b00; vl_i = 7'd9; src_step_i = 7'd4; dst_step_i = 7'd2;
        src_zero_en_i = 0; dst_zero_en_i = 0;
        int_src_mask_i = '0; int_dst_mask_i = '0;
        run_case("R2 none");
        check("R2 src unchanged", src_step_o, 4);

        // R3 twin selects separate source mask
        pred_mode_i = 2'b01; twin_i = 1; vl_i = 7'd20;
        src_step_i = 0; dst_step_i = 0;
        int_src_mask_i = 64'h0000_0000_0000_0100; int_dst_mask_i = 64'h0000_0000_0000_0008;
        run_case("R3 twin");
        check("R3 twin src", src_step_o, 8);
        twin_i = 0;
        run_case("R3 single");
        check("R3 single src", src_step_o, 3);

        // R4 condition mode truncates mask above VL
        pred_mode_i = 2'b10; vl_i = 7'd3; src_step_i = 7'd5; dst_step_i = 7'd1;
        src_zero_en_i = 1; dst_zero_en_i = 0;
        cr_src_mask_i = '1; cr_dst_mask_i = '1;
        run_case("R4 cr");
        check("R4 cr zero past vl", src_zero_o, 1);
        pred_mode_i = 2'b01; int_src_mask_i = '1; int_dst_mask_i = '1;
        run_case("R4 int compare");
        check("R4 int no zero", src_zero_o, 0);

        // R5 index beyond mask width walks to sentinel
        src_zero_en_i = 0; vl_i = 7'd100; src_step_i = 7'd70; dst_step_i = 7'd0;
        run_case("R5 high");
        check("R5 high end", src_step_o, 100);

        // R8 zero length
        pred_mode_i = 2'b00; vl_i = 0; src_step_i = 7'd3; dst_step_i = 7'd5;
        run_case("R8 vl0");
        check("R8 end at vl0", end_o, 1);

        // R10 start while busy is ignored; hold after done
        pred_mode_i = 2'b01; twin_i = 0; vl_i = 7'd40; src_step_i = 0; dst_step_i = 0;
        src_zero_en_i = 0; dst_zero_en_i = 0;
        int_dst_mask_i = 64'h0000_0080_0000_0000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        vl_i = 7'd2; src_step_i = 7'd1; dst_step_i = 7'd1; int_dst_mask_i = '1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 140000) @(negedge clk);
        check("R10 busy start ignored", src_step_o, 39);
        check("R10 busy start ignored dst", dst_step_o, 39);
        repeat (5) @(negedge clk);
        check("R10 hold done", done_o, 1);
        check("R10 hold index", dst_step_o, 39);
        check("R10 hold end", end_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule